// File: doc/BRIEF.md
# Oscillator Band Search Controller

This controller picks one of a bank of oscillator bands for a frequency synthesizer. When software writes the low byte of the divider while automatic selection is enabled, the controller loads a software-given starting band. It waits a fixed settle time, reads the 3-bit tuning-voltage converter code, and then either accepts the band or steps one band up or down. It keeps doing this until the code falls inside a narrow acceptance window, or until the search is declared a failure.

Two status flags report the outcome. An idle flag is low while a search runs and high otherwise. A success flag is high only after a search that ended inside the window. When automatic selection is disabled, the band output follows the programmed code directly. In that mode software runs the converter and captures its reading into a readback field with a separate latch strobe. The active band and the captured code are also presented together as one status byte.

Top module: `vco_band_seeker`

## Requirements
- R1: After reset, search_idle_o=1, search_ok_o=0, adc_rb_o=000, and with auto_en_i=1 band_o=0.
- R2: With auto_en_i=0, band_o equals start_band_i in the same cycle and adc_conv_en_o equals conv_en_i. With auto_en_i=1, adc_conv_en_o is high exactly while a search runs.
- R3: A clock edge with start_i=1 and auto_en_i=1 and start_band_i<NUM_BANDS loads start_band_i as the band. search_idle_o is 0 from the next cycle, and search_ok_o stays 0 while the search runs.
- R4: The converter code is sampled SETTLE_CYCLES clocks after each band change. A search of k evaluations that started on edge E0 ends (search_idle_o=1) on edge E0+k*SETTLE_CYCLES.
- R5: A sampled code of 010 or 101 ends the search with search_ok_o=1. The band is held and adc_rb_o shows that code.
- R6: Codes 000, 001 and 011 step the band down by one. Codes 100, 110 and 111 step it up by one.
- R7: If a step would leave bands 0..NUM_BANDS-1, or NUM_BANDS evaluations have been made without a hit, the search ends with search_idle_o=1 and search_ok_o=0. band_o keeps the last evaluated band and adc_rb_o keeps the last sampled code.
- R8: If the step direction reverses within one search, the search ends as a failure at the band just evaluated.
- R9: A start with start_band_i>=NUM_BANDS fails at once. search_idle_o stays 1, search_ok_o becomes 0, and band_o shows the programmed value.
- R10: A start strobe during a search restarts it from the current start_band_i, with a fresh settle count, evaluation count and direction history.
- R11: Clearing auto_en_i during a search ends it as a failure on the next edge.
- R12: With auto_en_i=0, a latch_i pulse while conv_en_i=1 copies adc_code_i into adc_rb_o on that edge. A latch with conv_en_i=0, or any latch while auto_en_i=1, leaves adc_rb_o unchanged.
- R13: status_o has band_o in bits 7:3 and adc_rb_o in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Divider low-byte write strobe; starts a search |
| auto_en_i | input | 1 | Automatic band selection enable |
| start_band_i | input | BAND_W | Programmed band: manual selection and search start |
| adc_code_i | input | 3 | Tuning-voltage converter code |
| conv_en_i | input | 1 | Manual converter enable |
| latch_i | input | 1 | Manual capture strobe |
| band_o | output | BAND_W | Active band |
| search_idle_o | output | 1 | 0 while a search runs, 1 otherwise |
| search_ok_o | output | 1 | 1 after a successful search |
| adc_rb_o | output | 3 | Captured converter code |
| status_o | output | BAND_W+3 | Active band and captured code |
| adc_conv_en_o | output | 1 | Converter enable toward the analog side |

## Verification
The bench models the tuning voltage as a function of the distance between the active band and a target band. It times every search to the exact edge. A design that sampled one cycle early or late, or that miscounted settle cycles after a step, ends busy or idle in the wrong cycle. The corner cases covered are:
- A hit only on the last band after a full 24-band climb. A design that checked the evaluation limit before the hit would report failure here.
- Runs off either end of the bank.
- An oscillating converter, which a design without reversal detection would walk to an edge.
- The mid-scale codes 011 and 100, where swapped step directions go the wrong way.
- An out-of-range starting band, a restart mid-search, an abort, and manual latches with the enable low or automatic mode on. Each of these would show a stale flag or a changed readback if handled wrongly.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  localparam int ADC_W = 3;

  localparam logic [ADC_W-1:0] CODE_WIN_LO = 3'b010;
  localparam logic [ADC_W-1:0] CODE_WIN_HI = 3'b101;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_SEEK = 1'b1
  } seek_state_e;

  // Outcome of one converter sample
  typedef struct packed {
    logic hit;  // inside acceptance window
    logic up;   // step direction when not a hit
  } verdict_t;

endpackage

// File: rtl/vbs_code_judge.sv
module vbs_code_judge
  import vbs_pkg::*;
(
  input  logic [ADC_W-1:0] code_i,
  output verdict_t         verdict_o
);

  always_comb begin
    verdict_o = '{hit: 1'b0, up: 1'b0};
    unique case (code_i)
      CODE_WIN_LO, CODE_WIN_HI: verdict_o.hit = 1'b1;
      3'b000, 3'b001, 3'b011:   verdict_o.up  = 1'b0;  // voltage low side: go down
      3'b100, 3'b110, 3'b111:   verdict_o.up  = 1'b1;  // voltage high side: go up
      default:                  verdict_o.up  = 1'b0;
    endcase
  end

endmodule

// File: rtl/vbs_settle_timer.sv
module vbs_settle_timer #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire_o = run_i && (cnt_q == CNT_LAST);
  assign cnt_en   = clr_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (run_i)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4: the count never passes the settle window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < SETTLE_CYCLES);

endmodule

// File: rtl/vbs_readback.sv
module vbs_readback
  import vbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode_i,
  input  logic             conv_en_i,
  input  logic             latch_i,
  input  logic             smp_valid_i,
  input  logic [ADC_W-1:0] code_i,
  output logic [ADC_W-1:0] rb_o
);

  logic [ADC_W-1:0] rb_q;
  logic             man_cap;
  logic             rb_en;

  assign man_cap = !auto_mode_i && conv_en_i && latch_i;
  assign rb_en   = smp_valid_i || man_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rb_q <= '0;
    else if (rb_en) rb_q <= code_i;
  end

  assign rb_o = rb_q;

  // R12: a manual capture shows the converter code one edge later
  p_manual_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode_i && conv_en_i && latch_i) |=> (rb_q == $past(code_i)));

  // R12: manual latch with the converter disabled changes nothing
  p_latch_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_en_i && !smp_valid_i) |=> $stable(rb_q));

endmodule

// File: rtl/vco_band_seeker.sv
module vco_band_seeker
  import vbs_pkg::*;
#(
  parameter int NUM_BANDS     = 24,
  parameter int BAND_W        = 5,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    auto_en_i,
  input  logic [BAND_W-1:0]       start_band_i,
  input  logic [2:0]              adc_code_i,
  input  logic                    conv_en_i,
  input  logic                    latch_i,
  output logic [BAND_W-1:0]       band_o,
  output logic                    search_idle_o,
  output logic                    search_ok_o,
  output logic [2:0]              adc_rb_o,
  output logic [BAND_W+ADC_W-1:0] status_o,
  output logic                    adc_conv_en_o
);

  localparam int                EVAL_W   = $clog2(NUM_BANDS + 1);
  localparam logic [BAND_W-1:0] BAND_TOP = BAND_W'(NUM_BANDS - 1);
  localparam logic [EVAL_W-1:0] EVAL_MAX = EVAL_W'(NUM_BANDS);

  seek_state_e       state_q, state_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic [EVAL_W-1:0] evals_q, evals_d, evals_inc;
  logic              dirv_q, dirv_d;
  logic              dirup_q, dirup_d;
  logic              ok_q, ok_d;

  logic     start_go, start_oob, sample, tmr_clr, tmr_expire;
  logic     at_floor, at_ceil, reversed, edge_hit;
  verdict_t verdict;

  // ---------------------------------------------------------------- helpers
  vbs_code_judge u_judge (
    .code_i    (adc_code_i),
    .verdict_o (verdict)
  );

  vbs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .run_i    (state_q == S_SEEK),
    .expire_o (tmr_expire)
  );

  vbs_readback u_rb (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_mode_i (auto_en_i),
    .conv_en_i   (conv_en_i),
    .latch_i     (latch_i),
    .smp_valid_i (sample),
    .code_i      (adc_code_i),
    .rb_o        (adc_rb_o)
  );

  // ------------------------------------------------------------ next state
  assign start_go  = start_i && auto_en_i;
  assign start_oob = int'(start_band_i) >= NUM_BANDS;
  assign sample    = (state_q == S_SEEK) && tmr_expire && auto_en_i;
  assign evals_inc = evals_q + EVAL_W'(1);
  assign at_floor  = (band_q == '0);
  assign at_ceil   = (band_q == BAND_TOP);
  assign reversed  = dirv_q && (dirup_q != verdict.up);
  assign edge_hit  = verdict.up ? at_ceil : at_floor;

  always_comb begin
    state_d = state_q;
    band_d  = band_q;
    evals_d = evals_q;
    dirv_d  = dirv_q;
    dirup_d = dirup_q;
    ok_d    = ok_q;
    tmr_clr = 1'b0;
    if (start_go) begin
      ok_d    = 1'b0;
      evals_d = '0;
      dirv_d  = 1'b0;
      dirup_d = 1'b0;
      band_d  = start_band_i;
      tmr_clr = 1'b1;
      state_d = start_oob ? S_IDLE : S_SEEK;
    end else if (state_q == S_SEEK && !auto_en_i) begin
      state_d = S_IDLE;
      ok_d    = 1'b0;
    end else if (sample) begin
      evals_d = evals_inc;
      if (verdict.hit) begin
        state_d = S_IDLE;
        ok_d    = 1'b1;
      end else if (reversed || (evals_inc >= EVAL_MAX) || edge_hit) begin
        state_d = S_IDLE;
        ok_d    = 1'b0;
      end else begin
        band_d  = verdict.up ? band_q + BAND_W'(1) : band_q - BAND_W'(1);
        dirv_d  = 1'b1;
        dirup_d = verdict.up;
        tmr_clr = 1'b1;
      end
    end
  end

  // ------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      band_q  <= '0;
      evals_q <= '0;
      dirv_q  <= 1'b0;
      dirup_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      band_q  <= band_d;
      evals_q <= evals_d;
      dirv_q  <= dirv_d;
      dirup_q <= dirup_d;
      ok_q    <= ok_d;
    end
  end

  // --------------------------------------------------------------- outputs
  assign band_o        = auto_en_i ? band_q : start_band_i;
  assign search_idle_o = (state_q == S_IDLE);
  assign search_ok_o   = ok_q;
  assign status_o      = {band_o, adc_rb_o};
  assign adc_conv_en_o = auto_en_i ? (state_q == S_SEEK) : conv_en_i;

  // ------------------------------------------------------------ assertions
  // R3: an in-range start makes the block busy on the next edge
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !start_oob) |=> !search_idle_o);

  // R3: success flag stays low while searching
  p_ok_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !search_idle_o |-> !search_ok_o);

  // R5: success is only ever reported with a window code in the readback
  p_win_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_ok_o) |-> (adc_rb_o == CODE_WIN_LO || adc_rb_o == CODE_WIN_HI));

  // R6: within a search the band moves by at most one per evaluation
  p_band_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !start_go) |=>
      (band_q == $past(band_q) || band_q == $past(band_q) + BAND_W'(1) ||
       band_q == $past(band_q) - BAND_W'(1)));

  // R7: the searched band stays inside the bank, evaluations stay bounded
  p_band_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SEEK) |-> int'(band_q) < NUM_BANDS);

  p_eval_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evals_q <= EVAL_MAX);

  // R9: out-of-range start reports failure without going busy
  p_oob_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && start_oob) |=> (search_idle_o && !search_ok_o));

  // R11: dropping the enable aborts a search on the next edge
  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en_i && state_q == S_SEEK) |=> (search_idle_o && !search_ok_o));

endmodule

// File: tb/vco_band_seeker_tb.sv
module vco_band_seeker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int NB         = 24;
  localparam int NVEC       = 10;

  typedef struct packed {
    logic [1:0]        mode;   // 0 model/010, 1 model/101, 2 parity, 3 fixed code
    logic [4:0]        sb;
    logic signed [7:0] tgt;
    logic [2:0]        kcode;
    logic              ok;
    logic [4:0]        band;
    logic [2:0]        adc;
    logic [5:0]        evals;
  } vec_t;

  // Expected values worked out from the requirements
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 5'd10,  8'sd10, 3'd0,   1'b1, 5'd10, 3'b010, 6'd1},   // R5 immediate hit
    '{2'd0, 5'd5,   8'sd12, 3'd0,   1'b1, 5'd12, 3'b010, 6'd8},   // R6 climb
    '{2'd0, 5'd20,  8'sd3,  3'd0,   1'b1, 5'd3,  3'b010, 6'd18},  // R6 descend
    '{2'd1, 5'd0,   8'sd23, 3'd0,   1'b1, 5'd23, 3'b101, 6'd24},  // R5 hit on last eval
    '{2'd0, 5'd20,  8'sd30, 3'd0,   1'b0, 5'd23, 3'b111, 6'd4},   // R7 top edge
    '{2'd0, 5'd2,  -8'sd5,  3'd0,   1'b0, 5'd0,  3'b000, 6'd3},   // R7 bottom edge
    '{2'd2, 5'd4,   8'sd0,  3'd0,   1'b0, 5'd5,  3'b000, 6'd2},   // R8 reversal
    '{2'd3, 5'd3,   8'sd0,  3'b011, 1'b0, 5'd0,  3'b011, 6'd4},   // R6 011 goes down
    '{2'd3, 5'd21,  8'sd0,  3'b100, 1'b0, 5'd23, 3'b100, 6'd3},   // R6 100 goes up
    '{2'd0, 5'd23,  8'sd23, 3'd0,   1'b1, 5'd23, 3'b010, 6'd1}    // R5 top band hit
  };

  logic       clk, rst_n;
  logic       start, auto_en, conv_en, latch;
  logic [4:0] start_band;
  logic [2:0] adc_code;
  logic [4:0] band;
  logic       idle, ok, conv_out;
  logic [2:0] adc_rb;
  logic [7:0] status;

  int         mdl_mode, mdl_tgt;
  logic [2:0] mdl_code;
  int         total, bad;
  bit         done;

  vco_band_seeker #(.NUM_BANDS(NB), .BAND_W(5), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .auto_en_i     (auto_en),
    .start_band_i  (start_band),
    .adc_code_i    (adc_code),
    .conv_en_i     (conv_en),
    .latch_i       (latch),
    .band_o        (band),
    .search_idle_o (idle),
    .search_ok_o   (ok),
    .adc_rb_o      (adc_rb),
    .status_o      (status),
    .adc_conv_en_o (conv_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Tuning-voltage model: code depends on distance from a target band
  always_comb begin
    int d;
    d = int'(band) - mdl_tgt;
    case (mdl_mode)
      0, 1: begin
        if (d >= 2)       adc_code = 3'b000;
        else if (d == 1)  adc_code = 3'b001;
        else if (d == 0)  adc_code = (mdl_mode == 1) ? 3'b101 : 3'b010;
        else if (d == -1) adc_code = 3'b110;
        else              adc_code = 3'b111;
      end
      2:       adc_code = band[0] ? 3'b000 : 3'b111;
      default: adc_code = mdl_code;
    endcase
  end

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [4:0] sb);
    @(negedge clk);
    start_band = sb;
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic pulse_latch();
    @(negedge clk);
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    string req;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; start = 1'b0; auto_en = 1'b1; conv_en = 1'b0; latch = 1'b0;
    start_band = '0; mdl_mode = 0; mdl_tgt = 0; mdl_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1", "idle", idle, 1);
    chk_eq("R1", "ok", ok, 0);
    chk_eq("R1", "adc_rb", adc_rb, 0);
    chk_eq("R1", "band", band, 0);

    // Vector table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      mdl_mode = int'(VECS[i].mode);
      mdl_tgt  = int'(VECS[i].tgt);
      mdl_code = VECS[i].kcode;
      pulse_start(VECS[i].sb);
      repeat (int'(VECS[i].evals) * SETTLE - 1) @(negedge clk);
      chk_eq("R4", "busy before last sample", idle, 0);
      chk_eq("R3", "ok low while busy", ok, 0);
      chk_eq("R2", "converter enabled while busy", conv_out, 1);
      @(negedge clk);
      chk_eq("R4", "idle after last sample", idle, 1);
      req = (VECS[i].mode == 2'd2) ? "R8" : (VECS[i].ok ? "R5" : "R7");
      chk_eq(req, "ok flag", ok, int'(VECS[i].ok));
      chk_eq(req, "band", band, int'(VECS[i].band));
      chk_eq(req, "adc readback", adc_rb, int'(VECS[i].adc));
      chk_eq("R13", "status byte", status, int'({VECS[i].band, VECS[i].adc}));
      repeat (2) @(negedge clk);
    end

    // R10 restart mid-search from a new start band
    mdl_mode = 0; mdl_tgt = 15;
    pulse_start(5'd10);
    repeat (2) @(negedge clk);
    pulse_start(5'd14);
    repeat (2 * SETTLE - 1) @(negedge clk);
    chk_eq("R10", "busy after restart", idle, 0);
    @(negedge clk);
    chk_eq("R10", "idle after restart", idle, 1);
    chk_eq("R10", "ok after restart", ok, 1);
    chk_eq("R10", "band after restart", band, 15);

    // R9 out-of-range start, right after a success
    pulse_start(5'd26);
    chk_eq("R9", "idle", idle, 1);
    chk_eq("R9", "ok", ok, 0);
    chk_eq("R9", "band", band, 26);
    repeat (2) @(negedge clk);
    chk_eq("R9", "still idle", idle, 1);

    // R11 abort by clearing the enable
    mdl_mode = 0; mdl_tgt = 20;
    pulse_start(5'd5);
    repeat (2) @(negedge clk);
    chk_eq("R11", "busy before abort", idle, 0);
    auto_en = 1'b0;
    @(negedge clk);
    chk_eq("R11", "idle after abort", idle, 1);
    chk_eq("R11", "ok after abort", ok, 0);
    auto_en = 1'b1;
    repeat (SETTLE + 2) @(negedge clk);
    chk_eq("R11", "stays idle", idle, 1);

    // R2 / R12 / R13 manual mode
    @(negedge clk);
    auto_en = 1'b0; conv_en = 1'b1; start_band = 5'd7;
    mdl_mode = 3; mdl_code = 3'b110;
    #1;
    chk_eq("R2", "band follows program", band, 7);
    chk_eq("R2", "converter enable follows", conv_out, 1);
    start_band = 5'd12;
    #1;
    chk_eq("R2", "band follows new program", band, 12);
    start_band = 5'd7;
    pulse_latch();
    chk_eq("R12", "manual capture", adc_rb, 6);
    mdl_code = 3'b001; conv_en = 1'b0;
    pulse_latch();
    chk_eq("R12", "capture ignored with converter off", adc_rb, 6);
    chk_eq("R2", "converter enable low", conv_out, 0);
    auto_en = 1'b1; conv_en = 1'b1;
    pulse_latch();
    chk_eq("R12", "capture ignored in auto mode", adc_rb, 6);
    chk_eq("R2", "converter off when idle in auto", conv_out, 0);
    auto_en = 1'b0;
    #1;
    chk_eq("R13", "status byte manual", status, int'({5'd7, 3'b110}));

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule